// File: doc/BRIEF.md
# TDM Audio Frame Serializer

This block turns a set of eight audio samples into one serial bit stream for a multichannel codec on a time-division link. The bit clock and the frame sync come from outside; the block is a slave to both. Each frame is made of eight 32-bit time slots, 256 bit clocks in all. A rising frame sync is caught on the falling clock edge that follows it. The block then drives the first bit of slot 0 on the next rising edge, and one bit per rising edge after that. The receiver samples each bit on the falling edge in between.

Every slot carries its 24-bit sample in its upper bits, with zeros below it. A per-slot valid mask blanks whole slots to zero. A mono option copies the left sample of each left/right pair into the right slot. All inputs are captured together at the frame start, so one frame never mixes data from two updates. A frame sync rise that arrives before the current frame has finished restarts the frame and pulses a resync flag.

Top module: `tdm_slot_serializer`

## Requirements
- R1: From reset until the first frame start, `sdata` and `resync` stay at 0.
- R2: A low-to-high `fsync` change made after a rising `bclk` edge is sampled on the next falling edge. The MSB of slot 0 appears on `sdata` at the rising edge after that, and not before.
- R3: Slots go out in order 0 to 7, 32 bits each, MSB first. Slot i takes its sample from `sample_in[24*i+23:24*i]`.
- R4: In a valid slot, slot bits 31..8 carry the 24-bit sample and slot bits 7..0 are 0.
- R5: `slot_valid[i]` = 0 makes all 32 bits of slot i zero.
- R6: With `mono_en` = 1, each odd slot 2k+1 carries the sample and the valid bit of slot 2k. Even slots are unchanged.
- R7: Samples, the mask and `mono_en` are captured at the frame start. Changes made during a frame do not affect that frame.
- R8: Once 256 bits have been sent, `sdata` stays 0 until the next frame start.
- R9: A frame sync rise before all 256 bits are out restarts output at the slot 0 MSB. `resync` is high for exactly the one cycle in which that MSB is driven.
- R10: Frames whose sync rises are exactly 256 bit clocks apart run back to back with no gap and no `resync`.
- R11: Only a rising edge of `fsync` starts a frame. Holding `fsync` high starts nothing further.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; data launched on rising edge, sync sampled on falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | Frame sync; its rising edge marks a new frame |
| sample_in | input | 192 | Eight 24-bit samples, slot i in bits 24*i+23 down to 24*i |
| slot_valid | input | 8 | Bit i enables slot i |
| mono_en | input | 1 | Copy each even slot into the following odd slot |
| sdata | output | 1 | Serial data toward the codec |
| resync | output | 1 | One-cycle pulse when a frame is cut short by a new sync |

## Verification
The hardest cases to reach are the ones where one frame boundary meets the next. The first is a sync rise placed on exactly the 256th bit, which must not raise `resync`. The second is a rise placed mid-frame, which must raise `resync` and restart cleanly. The stimulus task can raise `fsync` in the same cycle in which the previous capture loop ends, so the spacing between rises is set to the bit. A forked process rewrites every input in the middle of a frame to show that the captured set is kept for that frame.

// File: rtl/tdm_ser_pkg.sv
// Package: shared frame geometry for the TDM slot serializer.
// Assumes 8 slots of 32 bits with 24-bit left-justified samples by default.
package tdm_ser_pkg;
    parameter int NUM_SLOTS   = 8;
    parameter int SLOT_BITS   = 32;
    parameter int SAMPLE_BITS = 24;
    localparam int FRAME_BITS = NUM_SLOTS * SLOT_BITS;
endpackage

// File: rtl/tdm_fsync_sampler.sv
// Module: tdm_fsync_sampler
// Samples frame sync on the falling bit-clock edge and flags its rising edge.
// Assumes fsync changes only near rising bclk edges; the start flag is held
// for one full bit period so the next rising edge sees it.
module tdm_fsync_sampler (
    input  logic bclk,
    input  logic rst_n,
    input  logic fsync,
    output logic start_pend
);
    logic fs_prev;

    // Falling-edge capture of sync and detection of its low-to-high change.
    always_ff @(negedge bclk) begin
        if (!rst_n) begin
            fs_prev    <= 1'b0;
            start_pend <= 1'b0;
        end else begin
            fs_prev    <= fsync;
            start_pend <= fsync & ~fs_prev;
        end
    end
endmodule

// File: rtl/tdm_frame_builder.sv
// Module: tdm_frame_builder
// Combinationally assembles the full frame image from samples, slot mask and
// mono option. Slot 0 sits at the image MSB end; samples are left-justified
// in their slots and the remaining bits are zero.
// Assumes SLOT_BITS >= SAMPLE_BITS and NUM_SLOTS is even when mono is used.
module tdm_frame_builder #(
    parameter int NUM_SLOTS   = 8,
    parameter int SLOT_BITS   = 32,
    parameter int SAMPLE_BITS = 24,
    localparam int FRAME_BITS = NUM_SLOTS * SLOT_BITS,
    localparam int PAD_BITS   = SLOT_BITS - SAMPLE_BITS
) (
    input  logic [NUM_SLOTS*SAMPLE_BITS-1:0] sample_in,
    input  logic [NUM_SLOTS-1:0]             slot_valid,
    input  logic                             mono_en,
    output logic [FRAME_BITS-1:0]            frame_img
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam int PAIR_SRC = (s % 2 == 1) ? s - 1 : s;
        logic                   use_pair;
        logic [SAMPLE_BITS-1:0] smp;
        logic                   vld;

        // Pick the source slot: odd slots borrow their even partner in mono.
        always_comb begin
            use_pair = mono_en && (s % 2 == 1);
            smp = use_pair ? sample_in[PAIR_SRC*SAMPLE_BITS +: SAMPLE_BITS]
                           : sample_in[s*SAMPLE_BITS +: SAMPLE_BITS];
            vld = use_pair ? slot_valid[PAIR_SRC] : slot_valid[s];
        end

        // Place the left-justified slot word, zeroed when not valid.
        always_comb begin
            frame_img[FRAME_BITS-1-s*SLOT_BITS -: SLOT_BITS] =
                vld ? {smp, {PAD_BITS{1'b0}}} : '0;
        end
    end
endmodule

// File: rtl/tdm_bit_shifter.sv
// Module: tdm_bit_shifter
// Loads the frame image at frame start and shifts it out MSB first, one bit
// per rising bclk edge. Counts bits sent, drives zero once the frame is done,
// and pulses resync when a start arrives mid-frame.
// Assumes start_pend is stable around each rising edge.
module tdm_bit_shifter #(
    parameter int FRAME_BITS = 256,
    localparam int CNT_W     = $clog2(FRAME_BITS + 1)
) (
    input  logic                  bclk,
    input  logic                  rst_n,
    input  logic                  start_pend,
    input  logic [FRAME_BITS-1:0] frame_img,
    output logic                  sdata,
    output logic                  resync
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS);

    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      bit_cnt;
    logic                  in_frame;

    // A frame is in progress while some but not all bits have gone out.
    always_comb in_frame = (bit_cnt != '0) && (bit_cnt < LAST_CNT);

    // Rising-edge launch: load on start, shift during frame, idle at zero.
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            sdata   <= 1'b0;
            resync  <= 1'b0;
        end else if (start_pend) begin
            sdata   <= frame_img[FRAME_BITS-1];
            shreg   <= {frame_img[FRAME_BITS-2:0], 1'b0};
            bit_cnt <= CNT_W'(1);
            resync  <= in_frame;
        end else begin
            resync <= 1'b0;
            if (in_frame) begin
                sdata   <= shreg[FRAME_BITS-1];
                shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
                bit_cnt <= bit_cnt + CNT_W'(1);
            end else begin
                sdata <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tdm_slot_serializer.sv
// Module: tdm_slot_serializer (top)
// Serializes eight time slots per frame onto one data line, slaved to an
// external bit clock and frame sync. Assumes bclk is free-running and fsync
// changes on rising bclk edges.
module tdm_slot_serializer #(
    parameter int NUM_SLOTS   = tdm_ser_pkg::NUM_SLOTS,
    parameter int SLOT_BITS   = tdm_ser_pkg::SLOT_BITS,
    parameter int SAMPLE_BITS = tdm_ser_pkg::SAMPLE_BITS,
    localparam int FRAME_BITS = NUM_SLOTS * SLOT_BITS
) (
    input  logic                             bclk,
    input  logic                             rst_n,
    input  logic                             fsync,
    input  logic [NUM_SLOTS*SAMPLE_BITS-1:0] sample_in,
    input  logic [NUM_SLOTS-1:0]             slot_valid,
    input  logic                             mono_en,
    output logic                             sdata,
    output logic                             resync
);
    logic                  start_pend;
    logic [FRAME_BITS-1:0] frame_img;

    tdm_fsync_sampler u_sync (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .fsync      (fsync),
        .start_pend (start_pend)
    );

    tdm_frame_builder #(
        .NUM_SLOTS   (NUM_SLOTS),
        .SLOT_BITS   (SLOT_BITS),
        .SAMPLE_BITS (SAMPLE_BITS)
    ) u_build (
        .sample_in  (sample_in),
        .slot_valid (slot_valid),
        .mono_en    (mono_en),
        .frame_img  (frame_img)
    );

    tdm_bit_shifter #(
        .FRAME_BITS (FRAME_BITS)
    ) u_shift (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .start_pend (start_pend),
        .frame_img  (frame_img),
        .sdata      (sdata),
        .resync     (resync)
    );
endmodule

// File: rtl/tdm_ser_checker.sv
// Module: tdm_ser_checker
// Property checker for the serializer. Keeps its own model of frame starts
// and the bit position, built from fsync alone, and relates it to sdata and
// resync. Attached to the top by the bind below.
module tdm_ser_checker #(
    parameter int FRAME_BITS  = 256,
    parameter int SLOT_BITS   = 32,
    parameter int SAMPLE_BITS = 24,
    localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
    input logic bclk,
    input logic rst_n,
    input logic fsync,
    input logic sdata,
    input logic resync
);
    logic             fs_prev_c;
    logic             pend_c;
    logic             started_c;
    logic [CNT_W-1:0] cnt_c;
    int               pos_c;

    // Independent falling-edge view of the sync rise.
    always_ff @(negedge bclk) begin
        if (!rst_n) begin
            fs_prev_c <= 1'b0;
            pend_c    <= 1'b0;
        end else begin
            fs_prev_c <= fsync;
            pend_c    <= fsync && !fs_prev_c;
        end
    end

    // Count of bits driven so far in the current frame, saturating at the end.
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            started_c <= 1'b0;
            cnt_c     <= '0;
        end else if (pend_c) begin
            started_c <= 1'b1;
            cnt_c     <= CNT_W'(1);
        end else if (cnt_c != '0 && int'(cnt_c) < FRAME_BITS) begin
            cnt_c <= cnt_c + CNT_W'(1);
        end
    end

    // Position within the slot of the bit now on sdata.
    always_comb pos_c = (int'(cnt_c) - 1) % SLOT_BITS;

    AST_IDLE_ZERO: assert property (@(posedge bclk) disable iff (!rst_n)
        !started_c |-> (!sdata && !resync)); // R1

    AST_LOW_BYTE_ZERO: assert property (@(posedge bclk) disable iff (!rst_n)
        (cnt_c != '0 && pos_c >= SAMPLE_BITS) |-> !sdata); // R4

    AST_TAIL_ZERO: assert property (@(posedge bclk) disable iff (!rst_n)
        (int'(cnt_c) == FRAME_BITS && !pend_c) |=> !sdata); // R8

    AST_RESYNC_ONE_CYCLE: assert property (@(posedge bclk) disable iff (!rst_n)
        resync |=> !resync); // R9

    AST_RESYNC_AT_RESTART: assert property (@(posedge bclk) disable iff (!rst_n)
        resync |-> (cnt_c == CNT_W'(1))); // R9
endmodule

bind tdm_slot_serializer tdm_ser_checker #(
    .FRAME_BITS  (FRAME_BITS),
    .SLOT_BITS   (SLOT_BITS),
    .SAMPLE_BITS (SAMPLE_BITS)
) u_chk (
    .bclk   (bclk),
    .rst_n  (rst_n),
    .fsync  (fsync),
    .sdata  (sdata),
    .resync (resync)
);

// File: tb/tb_tdm_slot_serializer.sv
// Bench for tdm_slot_serializer: a vector table of frame settings walked by
// one loop, then directed tests for reset, timing and frame-boundary cases.
module tb_tdm_slot_serializer;
    localparam int NS = 8;
    localparam int SB = 24;
    localparam int FB = 256;

    logic             bclk = 1'b0;
    logic             rst_n;
    logic             fsync;
    logic [NS*SB-1:0] sample_in;
    logic [NS-1:0]    slot_valid;
    logic             mono_en;
    logic             sdata;
    logic             resync;

    int n_run  = 0;
    int n_fail = 0;

    tdm_slot_serializer dut (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .fsync      (fsync),
        .sample_in  (sample_in),
        .slot_valid (slot_valid),
        .mono_en    (mono_en),
        .sdata      (sdata),
        .resync     (resync)
    );

    always #10 bclk = ~bclk;

    // Table entry fields: [32] mono, [31:24] valid mask, [23:0] sample seed.
    localparam logic [32:0] VEC [6] = '{
        {1'b0, 8'hFF, 24'hA5C381},
        {1'b0, 8'h5A, 24'h123456},
        {1'b1, 8'h55, 24'hFEDCBA},
        {1'b1, 8'hAA, 24'h0F0F0F},
        {1'b0, 8'h00, 24'hFFFFFF},
        {1'b1, 8'hFF, 24'h800001}
    };

    function automatic logic [NS*SB-1:0] make_samples(input logic [23:0] seed);
        logic [NS*SB-1:0] r;
        for (int s = 0; s < NS; s++)
            r[s*SB +: SB] = seed ^ (24'h01F3A5 * 24'(s + 1));
        return r;
    endfunction

    // Expected frame image written from R3..R6.
    function automatic logic [FB-1:0] exp_img(input logic [NS*SB-1:0] smp,
                                              input logic [NS-1:0] v,
                                              input logic m);
        logic [FB-1:0] img;
        img = '0;
        for (int s = 0; s < NS; s++) begin
            int src;
            src = (m && (s % 2 == 1)) ? s - 1 : s;
            img[FB-1-32*s -: 32] = v[src] ? {smp[src*SB +: SB], 8'h00} : 32'h0;
        end
        return img;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Raise fsync (now, or after the next rising edge) and capture nbits bits.
    task automatic send_frame(input bit immediate, input int nbits, input int hold,
                              output logic [FB-1:0] got, output int hits);
        got  = '0;
        hits = 0;
        if (!immediate) begin
            @(posedge bclk);
            #2;
        end
        fsync = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            @(posedge bclk);
            #5;
            got[FB-1-i] = sdata;
            hits += int'(resync);
            if (i == hold - 1) fsync = 1'b0;
        end
    endtask

    task automatic finish_up;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge bclk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        logic [FB-1:0]    got, got2, exp;
        logic [NS*SB-1:0] old_smp;
        int               hits, hits2;
        bit               ok;

        rst_n      = 1'b0;
        fsync      = 1'b0;
        sample_in  = '0;
        slot_valid = '0;
        mono_en    = 1'b0;
        repeat (4) @(posedge bclk);
        #2 rst_n = 1'b1;

        // R1: idle after reset
        ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(posedge bclk);
            #5;
            if (sdata !== 1'b0 || resync !== 1'b0) ok = 1'b0;
        end
        check(ok, "R1 idle output after reset", {62'h0, sdata, resync}, 64'h0);

        // R2: MSB appears one rising edge after the sampled sync rise
        sample_in  = '0;
        sample_in[23:0] = 24'h800001;
        slot_valid = 8'h01;
        @(posedge bclk);
        #2 fsync = 1'b1;
        #3 check(sdata === 1'b0, "R2 no data before sync sampled", 64'(sdata), 64'h0);
        @(posedge bclk);
        #5 check(sdata === 1'b1, "R2 slot0 MSB on next rising edge", 64'(sdata), 64'h1);
        fsync = 1'b0;
        repeat (300) @(posedge bclk);

        // Table walk: R3 R4 R5 R6
        for (int k = 0; k < 6; k++) begin
            sample_in  = make_samples(VEC[k][23:0]);
            slot_valid = VEC[k][31:24];
            mono_en    = VEC[k][32];
            exp = exp_img(sample_in, slot_valid, mono_en);
            send_frame(1'b0, FB, 3, got, hits);
            for (int s = 0; s < NS; s++)
                check(got[FB-1-32*s -: 32] === exp[FB-1-32*s -: 32],
                      $sformatf("R3 R4 R5 R6 vec %0d slot %0d", k, s),
                      64'(got[FB-1-32*s -: 32]), 64'(exp[FB-1-32*s -: 32]));
        end

        // R8: zeros after the last bit
        ok = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(posedge bclk);
            #5;
            if (sdata !== 1'b0) ok = 1'b0;
        end
        check(ok, "R8 line zero after frame end", 64'(sdata), 64'h0);

        // R10: exact 256-bit spacing, back to back
        sample_in  = make_samples(24'h3C3C3C);
        slot_valid = 8'hFF;
        mono_en    = 1'b0;
        exp = exp_img(sample_in, slot_valid, mono_en);
        send_frame(1'b0, FB, 3, got, hits);
        send_frame(1'b1, FB, 3, got2, hits2);
        check(got2 === exp, "R10 second back-to-back frame", 64'(got2[FB-1 -: 64]), 64'(exp[FB-1 -: 64]));
        check(hits + hits2 == 0, "R10 no resync at exact spacing", 64'(hits + hits2), 64'h0);

        // R9: early sync rise restarts and pulses resync once
        send_frame(1'b0, 100, 3, got, hits);
        sample_in = make_samples(24'h5A0F71);
        exp = exp_img(sample_in, slot_valid, mono_en);
        send_frame(1'b1, FB, 3, got2, hits2);
        check(hits == 0, "R9 no resync before the early rise", 64'(hits), 64'h0);
        check(hits2 == 1, "R9 resync high for one cycle", 64'(hits2), 64'h1);
        check(got2 === exp, "R9 restarted frame from slot 0", 64'(got2[FB-1 -: 64]), 64'(exp[FB-1 -: 64]));

        // R7: inputs changed mid-frame do not affect it
        sample_in  = make_samples(24'h9E3779);
        slot_valid = 8'hC3;
        mono_en    = 1'b0;
        old_smp    = sample_in;
        exp = exp_img(old_smp, 8'hC3, 1'b0);
        repeat (5) @(posedge bclk);
        fork
            send_frame(1'b0, FB, 3, got, hits);
            begin
                repeat (51) @(posedge bclk);
                #3;
                sample_in  = ~sample_in;
                slot_valid = ~slot_valid;
                mono_en    = 1'b1;
            end
        join
        check(got === exp, "R7 frame keeps inputs captured at start",
              64'(got[FB-1 -: 64]), 64'(exp[FB-1 -: 64]));

        // R11: fsync held high starts only one frame
        mono_en = 1'b0;
        repeat (5) @(posedge bclk);
        send_frame(1'b0, FB, 1000, got, hits);
        ok = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(posedge bclk);
            #5;
            if (sdata !== 1'b0 || resync !== 1'b0) ok = 1'b0;
        end
        check(ok, "R11 held sync starts nothing new", {62'h0, sdata, resync}, 64'h0);
        fsync = 1'b0;
        repeat (5) @(posedge bclk);

        finish_up();
    end
endmodule